// File: doc/BRIEF.md
# Programmable Interrupt Stimulus Controller

This block is a test-stimulus peripheral that sits beside a CPU core on the
core's output-port bus. The CPU writes to four port addresses to set it up. One
port selects an interrupt source number. One sets how many cycles the request
stays high. One arms a trigger that raises the request a programmed number of
cycles after the writing instruction has finished. The fourth reports the
outcome of a test run.

While the CPU acknowledges an interrupt, the block takes over the memory fetch
address. Each source owns a four-byte vector slot. Slot `s` starts at
`VEC_BASE + 4*s`, with a default `VEC_BASE` of 40h. The byte offset inside the
slot follows the acknowledge fetches, so that a 1-, 2- or 3-byte instruction
can be placed in the slot and handed to the core.

The port writes are a plain strobe and are always accepted. The block has no
back-pressure anywhere: one write with `wr_en` high counts as exactly one
write. `insn_end` pulses in the last cycle of every instruction. `ack_fetch`
pulses once for each acknowledge-cycle byte fetch.

Top module: `irq_stim_ctrl`

## Requirements
- R1: When synchronous reset is applied, `irq`, `done`, `pass`, `fail` and `vec_valid` are low, `vec_addr` is 0, the stored source is 0 and the stored width is 1 cycle.
- R2: A write to port 10h stores data bits [2:0] as the source number (0 to 7). The upper data bits are discarded.
- R3: A write of value n to port 11h arms the trigger. The first `insn_end` pulse at or after the write marks the end of that instruction. `irq` stays low until that pulse, and then rises exactly n+1 cycles after the `insn_end` cycle (n = 0 gives the first cycle of the next instruction).
- R4: A write to port 12h sets the pulse width w. Once raised, `irq` stays high for exactly w consecutive cycles, whatever `ack` does. A width of 0 behaves as 1.
- R5: While `ack` is high, `vec_valid` is high and `vec_addr` = 40h + 4*source + index. While `ack` is low, `vec_valid` is low and `vec_addr` is 0.
- R6: The index is 0 at the start of every acknowledge sequence. It advances by one after each cycle in which `ack_fetch` is high, stops at 2, and returns to 0 whenever `ack` is low.
- R7: A trigger write made while a countdown or a pulse is in progress drops `irq` and restarts the timing from the new write, using the newly written delay and the current width.
- R8: A write to port 20h sets `done`. Data 55h sets `pass` and clears `fail`. Data AAh sets `fail` and clears `pass`. Any other value leaves both low. `done` stays high until reset.
- R9: A write to any other port address, or port and data values driven without `wr_en`, changes no stored value and has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Output-port write strobe |
| wr_port | input | 8 | Output-port address |
| wr_data | input | 8 | Output-port data |
| insn_end | input | 1 | High in the last cycle of each instruction |
| ack | input | 1 | Interrupt acknowledge in progress |
| ack_fetch | input | 1 | One acknowledge-cycle byte fetch this cycle |
| irq | output | 1 | Interrupt request to the core |
| vec_valid | output | 1 | Fetch address override active |
| vec_addr | output | 16 | Override fetch address |
| done | output | 1 | Outcome port written |
| pass | output | 1 | Outcome was 55h |
| fail | output | 1 | Outcome was AAh |

## Verification
Two events can land in the same cycle: the trigger write and the `insn_end`
pulse that closes the writing instruction. Every delay/width pair is therefore
run twice, once with both strobes in the same cycle and once with `insn_end`
arriving two cycles after the write. The first high sample of `irq` must then
fall at the computed offset from the end pulse. The second collision is a fresh
trigger write that arrives while a pulse is high. The bench checks that `irq`
drops in the following cycle and that the new delay and width then apply in
full.

// File: rtl/irq_stim_pkg.sv
package irq_stim_pkg;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_WAIT_END,
    TS_COUNT,
    TS_PULSE
  } tmr_state_t;

  localparam logic [7:0] PORT_SRC_DEF   = 8'h10;
  localparam logic [7:0] PORT_TRIG_DEF  = 8'h11;
  localparam logic [7:0] PORT_WIDTH_DEF = 8'h12;
  localparam logic [7:0] PORT_RES_DEF   = 8'h20;
  localparam logic [7:0] CODE_PASS      = 8'h55;
  localparam logic [7:0] CODE_FAIL      = 8'hAA;

endpackage

// File: rtl/irq_stim_regs.sv
module irq_stim_regs
  import irq_stim_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          SRC_W      = 3,
  parameter logic [7:0]  PORT_SRC   = PORT_SRC_DEF,
  parameter logic [7:0]  PORT_TRIG  = PORT_TRIG_DEF,
  parameter logic [7:0]  PORT_WIDTH = PORT_WIDTH_DEF,
  parameter logic [7:0]  PORT_RES   = PORT_RES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_port,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SRC_W-1:0]  src,
  output logic [DATA_W-1:0] width,
  output logic              trig_wr,
  output logic [DATA_W-1:0] trig_val,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  logic hit_src, hit_width, hit_res;

  assign hit_src   = wr_en && (wr_port == PORT_SRC);
  assign hit_width = wr_en && (wr_port == PORT_WIDTH);
  assign hit_res   = wr_en && (wr_port == PORT_RES);
  assign trig_wr   = wr_en && (wr_port == PORT_TRIG);
  assign trig_val  = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      src   <= '0;
      width <= DATA_W'(1);
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      if (hit_src)   src   <= wr_data[SRC_W-1:0];
      if (hit_width) width <= wr_data;
      if (hit_res) begin
        done <= 1'b1;
        pass <= (wr_data[7:0] == CODE_PASS);
        fail <= (wr_data[7:0] == CODE_FAIL);
      end
    end
  end

endmodule

// File: rtl/irq_stim_timer.sv
module irq_stim_timer
  import irq_stim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] trig_val,
  input  logic [DATA_W-1:0] width,
  input  logic              insn_end,
  output logic              irq
);

  tmr_state_t        state_q, state_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] dly_q, dly_d;
  logic [DATA_W-1:0] wid_eff;
  logic [DATA_W-1:0] load_val;
  tmr_state_t        load_state;
  logic [DATA_W-1:0] load_cnt;

  assign wid_eff = (width == '0) ? DATA_W'(1) : width;

  // Value that starts the countdown: the write data when it lands together
  // with the end pulse, the held delay otherwise.
  assign load_val = trig_wr ? trig_val : dly_q;

  always_comb begin
    if (load_val == '0) begin
      load_state = TS_PULSE;
      load_cnt   = wid_eff;
    end else begin
      load_state = TS_COUNT;
      load_cnt   = load_val - DATA_W'(1);
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    if (trig_wr) begin
      dly_d = trig_val;
      if (insn_end) begin
        state_d = load_state;
        cnt_d   = load_cnt;
      end else begin
        state_d = TS_WAIT_END;
      end
    end else begin
      unique case (state_q)
        TS_WAIT_END: if (insn_end) begin
          state_d = load_state;
          cnt_d   = load_cnt;
        end
        TS_COUNT: begin
          if (cnt_q == '0) begin
            state_d = TS_PULSE;
            cnt_d   = wid_eff;
          end else begin
            cnt_d = cnt_q - DATA_W'(1);
          end
        end
        TS_PULSE: begin
          if (cnt_q <= DATA_W'(1)) state_d = TS_IDLE;
          else                     cnt_d   = cnt_q - DATA_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      cnt_q   <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dly_q   <= dly_d;
    end
  end

  assign irq = (state_q == TS_PULSE);

endmodule

// File: rtl/irq_stim_vector.sv
module irq_stim_vector #(
  parameter int              ADDR_W    = 16,
  parameter int              SRC_W     = 3,
  parameter int              SLOT_SH   = 2,
  parameter int              MAX_BYTES = 3,
  parameter logic [15:0]     VEC_BASE  = 16'h0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic              ack_fetch,
  input  logic [SRC_W-1:0]  src,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);

  localparam int IDX_W   = SLOT_SH;
  localparam int IDX_MAX = MAX_BYTES - 1;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || !ack) begin
      idx_q <= '0;
    end else if (ack_fetch && (int'(idx_q) < IDX_MAX)) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  logic [ADDR_W-1:0] slot_base;
  assign slot_base = ADDR_W'(VEC_BASE) + (ADDR_W'(src) << SLOT_SH);

  assign vec_valid = ack;
  assign vec_addr  = ack ? (slot_base + ADDR_W'(idx_q)) : '0;

endmodule

// File: rtl/irq_stim_ctrl.sv
module irq_stim_ctrl
  import irq_stim_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          SRC_W     = 3,
  parameter int          SLOT_SH   = 2,
  parameter int          MAX_BYTES = 3,
  parameter logic [15:0] VEC_BASE  = 16'h0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_port,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              insn_end,
  input  logic              ack,
  input  logic              ack_fetch,
  output logic              irq,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  logic [SRC_W-1:0]  src;
  logic [DATA_W-1:0] width;
  logic              trig_wr;
  logic [DATA_W-1:0] trig_val;

  irq_stim_regs #(
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .src      (src),
    .width    (width),
    .trig_wr  (trig_wr),
    .trig_val (trig_val),
    .done     (done),
    .pass     (pass),
    .fail     (fail)
  );

  irq_stim_timer #(
    .DATA_W (DATA_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .trig_wr  (trig_wr),
    .trig_val (trig_val),
    .width    (width),
    .insn_end (insn_end),
    .irq      (irq)
  );

  irq_stim_vector #(
    .ADDR_W    (ADDR_W),
    .SRC_W     (SRC_W),
    .SLOT_SH   (SLOT_SH),
    .MAX_BYTES (MAX_BYTES),
    .VEC_BASE  (VEC_BASE)
  ) u_vector (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .ack_fetch (ack_fetch),
    .src       (src),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
  );

endmodule

// File: rtl/irq_stim_chk.sv
module irq_stim_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              ack,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !done && !pass && !fail));

  // R6
  idx_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> (vec_addr[1:0] == 2'b00));

  // R6
  idx_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (vec_addr[1:0] != 2'b11));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R8
  verdict_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

endmodule

bind irq_stim_ctrl irq_stim_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .ack      (ack),
  .vec_addr (vec_addr),
  .done     (done),
  .pass     (pass),
  .fail     (fail)
);

// File: tb/irq_stim_ctrl_bench.sv
`timescale 1ns/1ps
module irq_stim_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_port;
  logic [7:0]  wr_data;
  logic        insn_end;
  logic        ack;
  logic        ack_fetch;
  logic        irq;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic        done, pass, fail;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  irq_stim_ctrl u_irq_stim_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .insn_end(insn_end), .ack(ack), .ack_fetch(ack_fetch), .irq(irq),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .done(done), .pass(pass),
    .fail(fail)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic port_wr(input logic [7:0] p, input logic [7:0] d, input logic with_end);
    wr_en = 1'b1; wr_port = p; wr_data = d; insn_end = with_end;
    tick();
    wr_en = 1'b0; insn_end = 1'b0;
  endtask

  // Trigger with delay n; gap 0 = end pulse in the write cycle, else gap cycles later.
  // Returns first high sample index and high count, sampled from the cycle after the end.
  task automatic fire(input int n, input int gap, output int first, output int highs);
    if (gap == 0) begin
      port_wr(8'h11, 8'(n), 1'b1);
    end else begin
      port_wr(8'h11, 8'(n), 1'b0);
      for (int g = 1; g < gap; g++) begin
        check("R3 low before end", int'(irq), 0);
        tick();
      end
      check("R3 low before end", int'(irq), 0);
      insn_end = 1'b1;
      tick();
      insn_end = 1'b0;
    end
    first = -1;
    highs = 0;
    for (int s = 0; s < n + 12; s++) begin
      if (irq) begin
        if (first < 0) first = s;
        highs++;
      end
      tick();
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int first, highs;
    rst = 1'b1; wr_en = 1'b0; wr_port = '0; wr_data = '0;
    insn_end = 1'b0; ack = 1'b0; ack_fetch = 1'b0;
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 done", int'(done), 0);
    check("R1 pass/fail", int'({pass, fail}), 0);
    check("R1 vec_valid", int'(vec_valid), 0);
    check("R1 vec_addr", int'(vec_addr), 0);
    ack = 1'b1; #1;
    check("R1 source 0", int'(vec_addr), 16'h40);
    tick(); ack = 1'b0; tick();
    fire(0, 0, first, highs);
    check("R1 default width first", first, 0);
    check("R1 default width 1", highs, 1);

    // R3 / R4 sweep of delay, width and end-pulse alignment
    for (int w = 0; w <= 4; w++) begin
      port_wr(8'h12, 8'(w), 1'b0);
      for (int n = 0; n <= 5; n++) begin
        for (int gap = 0; gap <= 2; gap += 2) begin
          fire(n, gap, first, highs);
          check("R3 rise offset", first, n);
          check("R4 width", highs, (w == 0) ? 1 : w);
        end
      end
    end

    // R4 pulse held while acknowledge toggles
    port_wr(8'h12, 8'd5, 1'b0);
    port_wr(8'h11, 8'd0, 1'b1);
    highs = 0;
    for (int s = 0; s < 10; s++) begin
      ack = (s == 1 || s == 2); ack_fetch = ack;
      if (irq) highs++;
      tick();
    end
    ack = 1'b0; ack_fetch = 1'b0;
    check("R4 held through ack", highs, 5);

    // R7 retrigger during pulse
    port_wr(8'h12, 8'd4, 1'b0);
    port_wr(8'h11, 8'd3, 1'b1);
    tick(); tick(); tick();
    check("R7 first pulse up", int'(irq), 1);
    tick();
    check("R7 pulse still up", int'(irq), 1);
    port_wr(8'h11, 8'd1, 1'b1);
    first = -1; highs = 0;
    for (int s = 0; s < 10; s++) begin
      if (irq) begin if (first < 0) first = s; highs++; end
      tick();
    end
    check("R7 restart offset", first, 1);
    check("R7 restart width", highs, 4);

    // R7 retrigger during countdown
    port_wr(8'h11, 8'd5, 1'b1);
    tick();
    fire(2, 0, first, highs);
    check("R7 countdown restart", first, 2);
    check("R7 countdown width", highs, 4);

    // R2 / R5 / R6 full sweep of sources and fetch counts
    for (int s = 0; s < 8; s++) begin
      port_wr(8'h10, 8'(s) | 8'hF8, 1'b0);
      for (int nf = 1; nf <= 4; nf++) begin
        for (int rep = 0; rep < 2; rep++) begin
          ack = 1'b1; ack_fetch = 1'b1;
          for (int f = 0; f < nf; f++) begin
            #1;
            check("R5 valid", int'(vec_valid), 1);
            check("R2 R5 R6 address", int'(vec_addr), 16'h40 + 4 * s + ((f > 2) ? 2 : f));
            tick();
          end
          ack_fetch = 1'b0; #1;
          check("R6 hold without fetch", int'(vec_addr), 16'h40 + 4 * s + ((nf > 2) ? 2 : nf));
          tick();
          ack = 1'b0; #1;
          check("R5 idle valid", int'(vec_valid), 0);
          check("R5 idle addr", int'(vec_addr), 0);
          tick();
        end
      end
    end

    // R9 foreign port and strobe-less writes
    port_wr(8'h10, 8'd3, 1'b0);
    port_wr(8'h13, 8'd6, 1'b1);
    port_wr(8'h90, 8'd6, 1'b1);
    wr_port = 8'h10; wr_data = 8'd5; tick();
    wr_port = 8'h11; wr_data = 8'd0; insn_end = 1'b1; tick(); insn_end = 1'b0;
    for (int s = 0; s < 6; s++) begin
      check("R9 no irq", int'(irq), 0);
      tick();
    end
    ack = 1'b1; #1;
    check("R9 source kept", int'(vec_addr), 16'h4C);
    tick(); ack = 1'b0; tick();
    check("R9 done untouched", int'(done), 0);
    fire(0, 0, first, highs);
    check("R9 width kept", highs, 4);

    // R8 outcome codes
    port_wr(8'h20, 8'h00, 1'b0);
    check("R8 other done", int'(done), 1);
    check("R8 other flags", int'({pass, fail}), 0);
    port_wr(8'h20, 8'h55, 1'b0);
    check("R8 pass", int'({done, pass, fail}), 3'b110);
    port_wr(8'h20, 8'hAA, 1'b0);
    check("R8 fail", int'({done, pass, fail}), 3'b101);
    port_wr(8'h20, 8'h54, 1'b0);
    check("R8 near code", int'({done, pass, fail}), 3'b100);

    // R1 reset again clears everything
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 reset clears flags", int'({done, pass, fail, irq}), 0);
    fire(0, 0, first, highs);
    check("R1 width back to 1", highs, 1);

    finish_run();
  end

endmodule